// File: doc/BRIEF.md
# Inter-processor mailbox register bank

This block lets one host CPU exchange short messages with three peer CPUs through memory-mapped registers. Each host-peer pair has two message boxes, one for each direction. A box holds eight 32-bit words: seven payload words that carry up to 28 bytes, starting with a protocol word that must be non-zero, plus one acknowledge word. An acknowledge is the value 0xDEADBEAF written there.

A sender fills the words of the other side's box. It then writes the box's trigger register with bit 6 (new data) or bit 7 (acknowledge). That sets the receiver's event bit. A maskable, registered interrupt line then tells the receiver to fetch the message. The receiver clears the protocol word once the message is consumed, and drops the event bit through a write-one-to-clear register.

Each CPU has a simple 32-bit register port. A write takes effect at the clock edge on which it is presented. Read data appears one cycle after the read request.

Top module: `mbx_bank`

## Requirements
- R1: After synchronous reset, all event bits, mask bits and message words are 0, every read returns 0 and every interrupt output is low.
- R2: Message word k (k = 0..7) sits at window offset 0x14 + 4k, and read data appears on the cycle after the read. On the host port, bit 14 = 0 with window bits [13:12] = p (1..3) addresses the host's receive box for peer p. On peer port p, bit 12 = 0 addresses that peer's own receive box and bit 12 = 1 its send target, the host's box for p. Unmapped offsets read 0, and each box is separate from every other box.
- R3: A write by peer p to trigger offset 0x10 of its send window sets host event bit p-1 if data bit 6 or bit 7 is 1. A trigger write with both of those bits 0 has no effect.
- R4: A host write with bit 6 or 7 to offset 0x10 of a remote window (address bit 14 = 1, window bits = p) sets the event bit of peer p, and only that peer's.
- R5: Writing the clear register (offset 0x4, host window 0, or a peer's own window) clears each event bit whose data bit is 1 (host bits [2:0], peer bit 0) and leaves the others. Writing 0xFF clears all of them.
- R6: If an event is set and cleared in the same cycle, the bit stays set.
- R7: Each interrupt output goes high one cycle after (event AND mask) becomes non-zero, and goes low one cycle after it becomes zero. The mask resets to 0.
- R8: The trigger register clears itself and reads 0.
- R9: If the sender and the receiver write the same word of a box in the same cycle, the sender's value is kept.
- R10: The event bits read at offset 0x0 and the mask at offset 0xC, in host window 0 (bits [2:0], bit p-1 for peer p) and in each peer's own window (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the read |
| host_irq | output | 1 | Host interrupt |
| peer_req | input | 3 | Per-peer access strobe |
| peer_we | input | 3 | Per-peer write enable |
| peer_addr | input | 3x16 | Per-peer byte address |
| peer_wdata | input | 3x32 | Per-peer write data |
| peer_rdata | output | 3x32 | Per-peer read data |
| peer_irq | output | 3 | Per-peer interrupt |

## Verification
The bench drives a clear and a trigger into the same event bit in the same cycle. A design that lets the clear win would lose a message. It drives the host and a peer into the same message word in the same cycle and checks that the sender's value is kept. It sends a trigger with neither bit 6 nor bit 7 set and checks that no event appears. It checks the interrupt while the mask is still 0 and again after masking, so a line that ignores the mask or lags by a cycle is caught. It also reads another peer's box and an unmapped offset, where a wrong window decode would show up as stray data.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW = 32;
  localparam int NWORD = 8;
  localparam int IW = $clog2(NWORD);
  localparam logic [7:0] OFF_STA  = 8'h00;
  localparam logic [7:0] OFF_CLR  = 8'h04;
  localparam logic [7:0] OFF_MASK = 8'h0C;
  localparam logic [7:0] OFF_GEN  = 8'h10;
  localparam logic [7:0] OFF_INFO = 8'h14;
  localparam logic [7:0] OFF_LAST = OFF_INFO + 8'(4 * (NWORD - 1));
  localparam int GEN_RX_BIT  = 6;
  localparam int GEN_ACK_BIT = 7;

  function automatic logic is_info(input logic [7:0] off);
    return (off >= OFF_INFO) && (off <= OFF_LAST) && (off[1:0] == 2'b00);
  endfunction

  function automatic logic [IW-1:0] info_idx(input logic [7:0] off);
    logic [7:0] d;
    d = off - OFF_INFO;
    return d[IW+1:2];
  endfunction

  function automatic logic gen_hit(input logic [DW-1:0] wd);
    return wd[GEN_RX_BIT] | wd[GEN_ACK_BIT];
  endfunction
endpackage

// File: rtl/mbx_box.sv
module mbx_box #(
  parameter int DW = 32,
  parameter int NW = 8,
  localparam int IW = $clog2(NW)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   snd_we,
  input  logic [IW-1:0]          snd_idx,
  input  logic [DW-1:0]          snd_wd,
  input  logic                   rcv_we,
  input  logic [IW-1:0]          rcv_idx,
  input  logic [DW-1:0]          rcv_wd,
  output logic [NW-1:0][DW-1:0]  words
);
  // Sender has priority on a same-word collision.
  always_ff @(posedge clk) begin
    if (rst) begin
      words <= '0;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (snd_we && snd_idx == IW'(i))
          words[i] <= snd_wd;
        else if (rcv_we && rcv_idx == IW'(i))
          words[i] <= rcv_wd;
      end
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_chk
    AST_SENDER_KEPT: assert property (@(posedge clk) disable iff (rst)
      (snd_we && snd_idx == IW'(i)) |=> words[i] == $past(snd_wd)); // R9
    AST_RECV_WRITE: assert property (@(posedge clk) disable iff (rst)
      (rcv_we && rcv_idx == IW'(i) && !(snd_we && snd_idx == IW'(i)))
      |=> words[i] == $past(rcv_wd)); // R2
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!(snd_we && snd_idx == IW'(i)) && !(rcv_we && rcv_idx == IW'(i)))
      |=> $stable(words[i])); // R2
  end
endmodule

// File: rtl/mbx_evt.sv
module mbx_evt #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wd,
  output logic [N-1:0] sta,
  output logic [N-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sta  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      sta <= (sta & ~clr) | set;
      if (mask_we) mask <= mask_wd;
      irq <= |(sta & mask);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> sta[i]); // R6
    AST_W1C: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !sta[i]); // R5
  end
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
    ((sta & mask) == '0) |=> !irq); // R7
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((sta & mask) != '0) |=> irq); // R7
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NPEER = 3,
  parameter int AW = 16,
  parameter int WIN_SHIFT = 12,
  localparam int WINW = $clog2(NPEER + 1),
  localparam int REM_BIT = WIN_SHIFT + WINW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       host_req,
  input  logic                       host_we,
  input  logic [AW-1:0]              host_addr,
  input  logic [DW-1:0]              host_wdata,
  output logic [DW-1:0]              host_rdata,
  output logic                       host_irq,
  input  logic [NPEER-1:0]           peer_req,
  input  logic [NPEER-1:0]           peer_we,
  input  logic [NPEER-1:0][AW-1:0]   peer_addr,
  input  logic [NPEER-1:0][DW-1:0]   peer_wdata,
  output logic [NPEER-1:0][DW-1:0]   peer_rdata,
  output logic [NPEER-1:0]           peer_irq
);
  logic [7:0]      h_off;
  logic [WINW-1:0] h_win;
  logic [WINW-1:0] h_slot;
  logic            h_rem, h_wr, h_rd, h_ctl;
  logic [NPEER-1:0] h_set, h_clr, h_sta, h_mask;
  logic             h_mask_we;
  logic [DW-1:0]    h_rmux;

  logic [NPEER-1:0][NWORD-1:0][DW-1:0] hb_words;
  logic [NPEER-1:0][NWORD-1:0][DW-1:0] pb_words;
  logic [NPEER-1:0] p_set, p_clr, p_mwe, p_sta, p_mask;

  assign h_off  = host_addr[7:0];
  assign h_win  = host_addr[WIN_SHIFT +: WINW];
  assign h_slot = h_win - WINW'(1);
  assign h_rem  = host_addr[REM_BIT];
  assign h_wr   = host_req && host_we;
  assign h_rd   = host_req && !host_we;
  assign h_ctl  = h_wr && !h_rem && (h_win == '0);
  assign h_clr  = (h_ctl && h_off == OFF_CLR) ? host_wdata[NPEER-1:0] : '0;
  assign h_mask_we = h_ctl && (h_off == OFF_MASK);

  mbx_evt #(.N(NPEER)) u_host_evt (
    .clk(clk), .rst(rst), .set(h_set), .clr(h_clr),
    .mask_we(h_mask_we), .mask_wd(host_wdata[NPEER-1:0]),
    .sta(h_sta), .mask(h_mask), .irq(host_irq)
  );

  for (genvar g = 0; g < NPEER; g++) begin : g_peer
    localparam logic [WINW-1:0] WIN_ID = WINW'(g + 1);
    logic [7:0] off;
    logic       rem, wr, rd;
    logic       hb_snd, hb_rcv, pb_snd, pb_rcv;
    logic [DW-1:0] rmux;

    assign off = peer_addr[g][7:0];
    assign rem = peer_addr[g][WIN_SHIFT];
    assign wr  = peer_req[g] && peer_we[g];
    assign rd  = peer_req[g] && !peer_we[g];

    // Host-side receive box for this peer: peer sends, host consumes.
    assign hb_snd = wr && rem && is_info(off);
    assign hb_rcv = h_wr && !h_rem && (h_win == WIN_ID) && is_info(h_off);
    // Peer-side receive box: host sends, peer consumes.
    assign pb_snd = h_wr && h_rem && (h_win == WIN_ID) && is_info(h_off);
    assign pb_rcv = wr && !rem && is_info(off);

    assign h_set[g] = wr && rem && (off == OFF_GEN) && gen_hit(peer_wdata[g]);
    assign p_set[g] = h_wr && h_rem && (h_win == WIN_ID) && (h_off == OFF_GEN)
                      && gen_hit(host_wdata);
    assign p_clr[g] = wr && !rem && (off == OFF_CLR) && peer_wdata[g][0];
    assign p_mwe[g] = wr && !rem && (off == OFF_MASK);

    mbx_box #(.DW(DW), .NW(NWORD)) u_hbox (
      .clk(clk), .rst(rst),
      .snd_we(hb_snd), .snd_idx(info_idx(off)), .snd_wd(peer_wdata[g]),
      .rcv_we(hb_rcv), .rcv_idx(info_idx(h_off)), .rcv_wd(host_wdata),
      .words(hb_words[g])
    );

    mbx_box #(.DW(DW), .NW(NWORD)) u_pbox (
      .clk(clk), .rst(rst),
      .snd_we(pb_snd), .snd_idx(info_idx(h_off)), .snd_wd(host_wdata),
      .rcv_we(pb_rcv), .rcv_idx(info_idx(off)), .rcv_wd(peer_wdata[g]),
      .words(pb_words[g])
    );

    mbx_evt #(.N(1)) u_evt (
      .clk(clk), .rst(rst), .set(p_set[g +: 1]), .clr(p_clr[g +: 1]),
      .mask_we(p_mwe[g]), .mask_wd(peer_wdata[g][0 +: 1]),
      .sta(p_sta[g +: 1]), .mask(p_mask[g +: 1]), .irq(peer_irq[g])
    );

    always_comb begin
      rmux = '0;
      if (!rem) begin
        if (off == OFF_STA)       rmux = DW'(p_sta[g]);
        else if (off == OFF_MASK) rmux = DW'(p_mask[g]);
        else if (is_info(off))    rmux = pb_words[g][info_idx(off)];
      end else if (is_info(off)) begin
        rmux = hb_words[g][info_idx(off)];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)     peer_rdata[g] <= '0;
      else if (rd) peer_rdata[g] <= rmux;
    end

    AST_PEER_TRIGGER: assert property (@(posedge clk) disable iff (rst)
      p_set[g] |=> p_sta[g]); // R4
  end

  always_comb begin
    h_rmux = '0;
    if (!h_rem) begin
      if (h_win == '0) begin
        if (h_off == OFF_STA)       h_rmux = DW'(h_sta);
        else if (h_off == OFF_MASK) h_rmux = DW'(h_mask);
      end else if (int'(h_win) <= NPEER && is_info(h_off)) begin
        h_rmux = hb_words[h_slot][info_idx(h_off)];
      end
    end else if (h_win != '0 && int'(h_win) <= NPEER && is_info(h_off)) begin
      h_rmux = pb_words[h_slot][info_idx(h_off)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       host_rdata <= '0;
    else if (h_rd) host_rdata <= h_rmux;
  end

  AST_TRIGGER_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    (h_set == '0 && h_clr == '0) |=> $stable(h_sta)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !h_rd |=> $stable(host_rdata)); // R2
endmodule

// File: tb/mbx_bank_tb_top.sv
module mbx_bank_tb_top;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic host_irq;
  logic [NP-1:0] peer_req = '0, peer_we = '0;
  logic [NP-1:0][15:0] peer_addr = '0;
  logic [NP-1:0][31:0] peer_wdata = '0;
  logic [NP-1:0][31:0] peer_rdata;
  logic [NP-1:0] peer_irq;

  always #10 clk = ~clk;

  mbx_bank dut_i (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .peer_req(peer_req), .peer_we(peer_we), .peer_addr(peer_addr),
    .peer_wdata(peer_wdata), .peer_rdata(peer_rdata), .peer_irq(peer_irq)
  );

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t sbq[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [15:0] hl(input int w, input int o);
    return 16'((w << 12) | o);
  endfunction
  function automatic logic [15:0] hr(input int w, input int o);
    return 16'(16'h4000 | (w << 12) | o);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic peer_wr(input int g, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    peer_req[g] = 1'b1; peer_we[g] = 1'b1; peer_addr[g] = a; peer_wdata[g] = d;
    @(negedge clk);
    peer_req[g] = 1'b0; peer_we[g] = 1'b0;
  endtask

  task automatic host_rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    it.src = 0; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic peer_rd(input int g, input logic [15:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    peer_req[g] = 1'b1; peer_we[g] = 1'b0; peer_addr[g] = a;
    it.src = g + 1; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    peer_req[g] = 1'b0;
  endtask

  // Monitor: a read seen at a rising edge is compared on the next falling edge.
  initial begin
    forever begin
      logic hit;
      rd_item_t it;
      logic [31:0] act;
      @(posedge clk);
      hit = (host_req && !host_we) || ((peer_req & ~peer_we) != '0);
      @(negedge clk);
      if (hit && !rst) begin
        if (sbq.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R2: actual=unexpected read expected=queued item");
        end else begin
          it = sbq.pop_front();
          act = (it.src == 0) ? host_rdata : peer_rdata[it.src-1];
          chk(act, it.exp, it.tag);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(32'(host_irq), 0, "R1 host irq after reset");
    chk(32'(peer_irq), 0, "R1 peer irq after reset");
    host_rd(hl(0, 'h00), 0, "R1 host status reset");
    host_rd(hl(0, 'h0C), 0, "R1 host mask reset");
    host_rd(hl(1, 'h14), 0, "R1 host box word reset");
    peer_rd(0, 16'h0030, 0, "R1 peer box word reset");

    // Peer 1 fills the host box: payload then acknowledge word.
    for (int k = 0; k < 7; k++) peer_wr(0, 16'(16'h1014 + 4*k), 32'h1000_0001 + 32'(k));
    peer_wr(0, 16'h1030, 32'hDEAD_BEAF);
    host_rd(hl(1, 'h14), 32'h1000_0001, "R2 protocol word");
    host_rd(hl(1, 'h20), 32'h1000_0004, "R2 word 3");
    host_rd(hl(1, 'h2C), 32'h1000_0007, "R2 word 6");
    host_rd(hl(1, 'h30), 32'hDEAD_BEAF, "R2 ack word");
    host_rd(hl(2, 'h14), 0, "R2 other box untouched");
    host_rd(hl(1, 'h08), 0, "R2 unmapped offset");
    peer_rd(0, 16'h1018, 32'h1000_0002, "R2 peer reads own send target");

    // Triggers into the host.
    peer_wr(0, 16'h1010, 32'h40);
    host_rd(hl(0, 'h00), 32'h1, "R3 data trigger sets bit 0");
    chk(32'(host_irq), 0, "R7 masked event keeps irq low");
    peer_wr(2, 16'h1010, 32'h80);
    peer_wr(1, 16'h1010, 32'h3F);
    host_rd(hl(0, 'h00), 32'h5, "R3 ack trigger sets bit 2, bare trigger ignored");
    peer_rd(0, 16'h1010, 0, "R8 trigger reads zero");
    host_rd(hr(1, 'h10), 0, "R8 remote trigger reads zero");

    host_wr(hl(0, 'h0C), 32'h1);
    @(negedge clk);
    chk(32'(host_irq), 1, "R7 irq rises after unmask");
    host_rd(hl(0, 'h0C), 32'h1, "R10 mask readback");
    host_wr(hl(0, 'h04), 32'h1);
    @(negedge clk);
    chk(32'(host_irq), 0, "R7 irq falls after clear");
    host_rd(hl(0, 'h00), 32'h4, "R5 clear leaves other bits");

    // Same-cycle clear and set on bit 2.
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = hl(0, 'h04); host_wdata = 32'h4;
    peer_req[2] = 1'b1; peer_we[2] = 1'b1; peer_addr[2] = 16'h1010; peer_wdata[2] = 32'h40;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0; peer_req[2] = 1'b0; peer_we[2] = 1'b0;
    host_rd(hl(0, 'h00), 32'h4, "R6 set wins over clear");
    host_wr(hl(0, 'h04), 32'hFF);
    host_rd(hl(0, 'h00), 0, "R5 clear all");

    // Host to peer 2.
    host_wr(hr(2, 'h14), 32'hA5A5_0001);
    host_wr(hr(2, 'h10), 32'h80);
    peer_rd(1, 16'h0000, 32'h1, "R4 peer 2 event set");
    peer_rd(0, 16'h0000, 0, "R4 peer 1 event untouched");
    peer_wr(1, 16'h000C, 32'h1);
    @(negedge clk);
    chk(32'(peer_irq), 32'h2, "R7 only peer 2 irq");
    peer_rd(1, 16'h000C, 32'h1, "R10 peer mask readback");
    peer_rd(1, 16'h0014, 32'hA5A5_0001, "R2 peer reads payload");
    peer_wr(1, 16'h0014, 0);
    peer_wr(1, 16'h0004, 32'h1);
    @(negedge clk);
    chk(32'(peer_irq), 0, "R7 peer irq falls");
    peer_rd(1, 16'h0000, 0, "R5 peer event cleared");
    peer_rd(1, 16'h0014, 0, "R2 protocol word consumed");

    // Same-word collisions.
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = hr(3, 'h18); host_wdata = 32'h111;
    peer_req[2] = 1'b1; peer_we[2] = 1'b1; peer_addr[2] = 16'h0018; peer_wdata[2] = 32'h222;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0; peer_req[2] = 1'b0; peer_we[2] = 1'b0;
    peer_rd(2, 16'h0018, 32'h111, "R9 host sender kept");
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = hl(3, 'h1C); host_wdata = 32'h333;
    peer_req[2] = 1'b1; peer_we[2] = 1'b1; peer_addr[2] = 16'h101C; peer_wdata[2] = 32'h444;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0; peer_req[2] = 1'b0; peer_we[2] = 1'b0;
    host_rd(hl(3, 'h1C), 32'h444, "R9 peer sender kept");

    repeat (3) @(negedge clk);
    chk(32'(sbq.size()), 0, "R2 all reads answered");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule